// File: doc/BRIEF.md
# Four-Channel Programmable Sound Generator

This block is a write-only sound source with three square-wave tone channels and one noise channel. Each channel has a 4-bit attenuation. A host drives it through a one-cycle write strobe and an 8-bit byte. Two kinds of byte share that one stream. A latch byte names a channel and a field and loads the low bits of that field. A data byte carries further bits for whichever field was named last.

The input clock goes through a divide-by-32 prescaler, and its tick steps the channel counters. The noise channel is a 16-bit shift register. It runs in periodic or white mode, from one of three fixed rates or from the toggles of tone channel 2. Each channel output bit gates the channel's volume into a registered 4-bit level, and a registered sum of the four levels is the digital mix.

Top module: `tone_noise_psg`

## Requirements
- R1: After reset all four levels and the mix read 0. Every attenuation resets to 15, every tone period resets to 0 and the noise control resets to 0.
- R2: A byte with bit 7 = 1 is a latch byte. Bits 6:5 select channel 0..3 (3 = noise), bit 4 selects attenuation (1) or tone/noise (0), and bits 3:0 are written into the low 4 bits of that field. A channel whose output bit is 1 shows a level of 15 minus its attenuation, and a channel whose output bit is 0 shows a level of 0.
- R3: A byte with bit 7 = 0 is a data byte. When an attenuation is latched, bits 3:0 replace that attenuation. The latch selection is left unchanged, and no other channel is affected.
- R4: When a tone period is latched, a data byte writes its bits 5:0 into bits 9:4 of the 10-bit period N. For N >= 2 the channel output toggles once every 32*N input clocks.
- R5: Each byte changes its register at once. A latch byte replaces bits 3:0 of the period and keeps bits 9:4, and the new period governs the following toggle intervals.
- R6: A tone period of 0 or 1 holds that channel's output bit at 1.
- R7: An attenuation of 15 gives a level of 0 whatever the output bit is.
- R8: Noise rate r = 0, 1, 2 shifts the register once every 16*2^r prescaler ticks (512, 1024 or 2048 clocks). In periodic mode the output is high for one shift period out of every 16.
- R9: The noise register is 16 bits wide. Every restart leaves only bit 15 set. Each shift moves it toward bit 0, and the output is bit 0. In white mode the bit shifted into bit 15 is bit 0 XOR bit 3. In periodic mode it is bit 0.
- R10: Noise rate 3 shifts the register once per toggle of tone channel 2.
- R11: The 3-bit noise control is bit 2 = white (1) or periodic (0) and bits 1:0 = rate. A data byte written while noise is latched sets the control from its bits 2:0, and every write to the noise control restarts the shift register.
- R12: The mix output equals the sum of the four levels, updated in the same cycle as the levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_data | input | 8 | Latch or data byte |
| tone0_lvl | output | 4 | Registered level of tone channel 0 |
| tone1_lvl | output | 4 | Registered level of tone channel 1 |
| tone2_lvl | output | 4 | Registered level of tone channel 2 |
| noise_lvl | output | 4 | Registered level of the noise channel |
| mix_out | output | 6 | Registered sum of the four levels |

## Verification
Some properties are checked by assertions on every cycle. A tone period of 0 or 1 forces the output bit high. A full attenuation gives a zero level on the next cycle. Data bytes never move the latch selection, and attenuations hold when no write is made. The noise register never falls into the all-zero state, and the mix stays within its range. The bench scenarios cover what needs history or long counts. These are the toggle intervals that follow a 10-bit period assembled from two bytes, the 16-shift rhythm of periodic noise at each rate, and the white-noise bit sequence compared against a model of the feedback. The scenarios also show that rate 3 follows the toggles of tone channel 2.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_TONE = 3;
  localparam int NOISE_CH = 3;
  typedef enum logic {FLD_PITCH = 1'b0, FLD_ATTEN = 1'b1} fld_e;
endpackage

// File: rtl/psg_regs.sv
module psg_regs
  import psg_pkg::*;
#(
  parameter int TONE_W = 10,
  parameter int VOL_W  = 4,
  parameter int CTL_W  = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [BYTE_W-1:0]                wr_data,
  output logic [NUM_TONE-1:0][TONE_W-1:0]  pitch_q,
  output logic [3:0][VOL_W-1:0]            atten_q,
  output logic [CTL_W-1:0]                 nctl_q,
  output logic                             noise_restart
);
  localparam int LO_W = 4;
  localparam int HI_W = TONE_W - LO_W;

  logic [1:0] sel_ch;
  fld_e       sel_fld;
  logic       is_latch;
  logic [1:0] byte_ch;
  fld_e       byte_fld;

  assign is_latch = wr_data[7];
  assign byte_ch  = wr_data[6:5];
  assign byte_fld = fld_e'(wr_data[4]);

  assign noise_restart = wr_en && (is_latch
      ? (byte_ch == 2'(NOISE_CH) && byte_fld == FLD_PITCH)
      : (sel_ch == 2'(NOISE_CH) && sel_fld == FLD_PITCH));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ch  <= '0;
      sel_fld <= FLD_PITCH;
      pitch_q <= '0;
      atten_q <= '1;
      nctl_q  <= '0;
    end else if (wr_en) begin
      if (is_latch) begin
        sel_ch  <= byte_ch;
        sel_fld <= byte_fld;
        if (byte_fld == FLD_ATTEN) begin
          atten_q[byte_ch] <= wr_data[VOL_W-1:0];
        end else if (byte_ch == 2'(NOISE_CH)) begin
          nctl_q <= wr_data[CTL_W-1:0];
        end else begin
          for (int i = 0; i < NUM_TONE; i++)
            if (byte_ch == 2'(i)) pitch_q[i][LO_W-1:0] <= wr_data[LO_W-1:0];
        end
      end else begin
        if (sel_fld == FLD_ATTEN) begin
          atten_q[sel_ch] <= wr_data[VOL_W-1:0];
        end else if (sel_ch == 2'(NOISE_CH)) begin
          nctl_q <= wr_data[CTL_W-1:0];
        end else begin
          for (int i = 0; i < NUM_TONE; i++)
            if (sel_ch == 2'(i)) pitch_q[i][TONE_W-1:LO_W] <= wr_data[HI_W-1:0];
        end
      end
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[7]) |=> (sel_ch == $past(sel_ch) && sel_fld == $past(sel_fld))); // R3
  AST_ATTEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(atten_q)); // R2
endmodule

// File: rtl/psg_tone.sv
module psg_tone #(
  parameter int TONE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [TONE_W-1:0] period,
  output logic              out_bit,
  output logic              toggle
);
  logic [TONE_W-1:0] cnt;
  logic              held;

  assign held   = (period <= TONE_W'(1));
  assign toggle = tick && !held && (cnt <= TONE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      out_bit <= 1'b0;
    end else if (tick) begin
      if (held) begin
        cnt     <= period;
        out_bit <= 1'b1;
      end else if (cnt <= TONE_W'(1)) begin
        cnt     <= period;
        out_bit <= ~out_bit;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (tick && period <= TONE_W'(1)) |=> out_bit); // R6
endmodule

// File: rtl/psg_noise.sv
module psg_noise #(
  parameter int LFSR_W   = 16,
  parameter int TAP_A    = 0,
  parameter int TAP_B    = 3,
  parameter int BASE_PER = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [2:0] ctl,
  input  logic       restart,
  input  logic       ext_step,
  output logic       out_bit
);
  localparam int CNT_W = $clog2(BASE_PER * 4) + 1;
  localparam logic [LFSR_W-1:0] SEED = {1'b1, {(LFSR_W-1){1'b0}}};

  logic [LFSR_W-1:0] lfsr;
  logic [CNT_W-1:0]  ncnt;
  logic [CNT_W-1:0]  per;
  logic              ext_rate;
  logic              step;
  logic              fb;

  assign ext_rate = (ctl[1:0] == 2'd3);
  assign per      = CNT_W'(BASE_PER) << ctl[1:0];
  assign step     = ext_rate ? ext_step : (tick && ncnt == '0);
  assign fb       = ctl[2] ? (lfsr[TAP_A] ^ lfsr[TAP_B]) : lfsr[0];
  assign out_bit  = lfsr[0];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      lfsr <= SEED;
      ncnt <= '0;
    end else begin
      if (tick && !ext_rate)
        ncnt <= (ncnt == '0) ? per - 1'b1 : ncnt - 1'b1;
      if (step)
        lfsr <= {fb, lfsr[LFSR_W-1:1]};
    end
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0); // R9
endmodule

// File: rtl/tone_noise_psg.sv
module tone_noise_psg
  import psg_pkg::*;
#(
  parameter int CLK_DIV = 32,
  parameter int TONE_W  = 10,
  parameter int VOL_W   = 4,
  parameter int LFSR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [VOL_W-1:0]  tone0_lvl,
  output logic [VOL_W-1:0]  tone1_lvl,
  output logic [VOL_W-1:0]  tone2_lvl,
  output logic [VOL_W-1:0]  noise_lvl,
  output logic [VOL_W+1:0]  mix_out
);
  localparam int PRE_W = $clog2(CLK_DIV);
  localparam int MIX_W = VOL_W + 2;
  localparam logic [VOL_W-1:0] FULL = '1;

  logic [PRE_W-1:0]                pre_cnt;
  logic                            tick;
  logic [NUM_TONE-1:0][TONE_W-1:0] pitch;
  logic [3:0][VOL_W-1:0]           atten;
  logic [2:0]                      nctl;
  logic                            n_restart;
  logic [3:0]                      ch_bit;
  logic [NUM_TONE-1:0]             ch_tog;
  logic [3:0][VOL_W-1:0]           lvl_d;
  logic [3:0][VOL_W-1:0]           lvl_q;
  logic [MIX_W-1:0]                mix_d;

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= (pre_cnt == PRE_W'(CLK_DIV - 1)) ? '0 : pre_cnt + 1'b1;
  end
  assign tick = (pre_cnt == PRE_W'(CLK_DIV - 1));

  psg_regs #(.TONE_W(TONE_W), .VOL_W(VOL_W), .CTL_W(3)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pitch_q(pitch), .atten_q(atten), .nctl_q(nctl), .noise_restart(n_restart)
  );

  for (genvar g = 0; g < NUM_TONE; g++) begin : g_tone
    psg_tone #(.TONE_W(TONE_W)) u_tone (
      .clk(clk), .rst(rst), .tick(tick), .period(pitch[g]),
      .out_bit(ch_bit[g]), .toggle(ch_tog[g])
    );
  end

  psg_noise #(.LFSR_W(LFSR_W), .TAP_A(0), .TAP_B(3), .BASE_PER(16)) u_noise (
    .clk(clk), .rst(rst), .tick(tick), .ctl(nctl), .restart(n_restart),
    .ext_step(ch_tog[2]), .out_bit(ch_bit[NOISE_CH])
  );

  always_comb begin
    mix_d = '0;
    for (int i = 0; i < 4; i++) begin
      lvl_d[i] = ch_bit[i] ? (FULL - atten[i]) : '0;
      mix_d    = mix_d + MIX_W'(lvl_d[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      mix_out <= '0;
    end else begin
      lvl_q   <= lvl_d;
      mix_out <= mix_d;
    end
  end

  assign tone0_lvl = lvl_q[0];
  assign tone1_lvl = lvl_q[1];
  assign tone2_lvl = lvl_q[2];
  assign noise_lvl = lvl_q[3];

  AST_MUTE_T0: assert property (@(posedge clk) disable iff (rst)
    (atten[0] == FULL) |=> (tone0_lvl == '0)); // R7
  AST_MUTE_NOISE: assert property (@(posedge clk) disable iff (rst)
    (atten[3] == FULL) |=> (noise_lvl == '0)); // R7
  AST_MIX_RANGE: assert property (@(posedge clk) disable iff (rst)
    mix_out <= MIX_W'(4 * FULL)); // R12
endmodule

// File: tb/tone_noise_psg_test.sv
module tone_noise_psg_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] tone0_lvl, tone1_lvl, tone2_lvl, noise_lvl;
  logic [5:0] mix_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tone_noise_psg uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tone0_lvl(tone0_lvl), .tone1_lvl(tone1_lvl), .tone2_lvl(tone2_lvl),
    .noise_lvl(noise_lvl), .mix_out(mix_out)
  );

  function automatic logic [3:0] get_lvl(input int idx);
    case (idx)
      0: return tone0_lvl;
      1: return tone1_lvl;
      2: return tone2_lvl;
      default: return noise_lvl;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_chg(input int idx, input int limit, output int cyc);
    logic [3:0] v;
    v = get_lvl(idx);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (get_lvl(idx) == v && cyc < limit);
  endtask

  task automatic wait_high(input int idx, input int limit);
    int c;
    c = 0;
    while (get_lvl(idx) == 0 && c < limit) begin @(negedge clk); c++; end
  endtask

  task automatic tone_interval(input int idx, input int exp, input string req);
    int c;
    wait_chg(idx, 40000, c);
    wait_chg(idx, 40000, c);
    wait_chg(idx, 40000, c);
    chk(c == exp, req, c, exp);
  endtask

  task automatic noise_shape(input int width, input int period, input string req);
    int w, g;
    wait_high(3, 70000);
    wait_chg(3, 70000, w);
    wait_chg(3, 70000, g);
    chk(w == width, {req, " high width"}, w, width);
    chk(w + g == period, {req, " period"}, w + g, period);
  endtask

  task automatic t_reset();
    chk(tone0_lvl == 0 && tone1_lvl == 0 && tone2_lvl == 0 && noise_lvl == 0,
        "R1 levels", {tone0_lvl, tone1_lvl, tone2_lvl, noise_lvl}, 0);
    chk(mix_out == 0, "R1 mix", mix_out, 0);
  endtask

  task automatic t_latch_volume();
    wr(8'h81); wr(8'h90); idle(40);
    chk(tone0_lvl == 15, "R2 ch0 atten 0", tone0_lvl, 15);
    wr(8'h96); idle(4);
    chk(tone0_lvl == 9, "R2 ch0 atten 6", tone0_lvl, 9);
  endtask

  task automatic t_data_volume();
    wr(8'hB2); idle(40);
    chk(tone1_lvl == 13, "R3 ch1 latch atten 2", tone1_lvl, 13);
    wr(8'h07); idle(4);
    chk(tone1_lvl == 8, "R3 ch1 data atten 7", tone1_lvl, 8);
    chk(tone0_lvl == 9, "R3 ch0 untouched", tone0_lvl, 9);
  endtask

  task automatic t_tone_period();
    wr(8'hBF);
    wr(8'h84); wr(8'h00);
    tone_interval(0, 128, "R4 period 4");
    wr(8'h01);
    tone_interval(0, 640, "R4 period 20");
  endtask

  task automatic t_tone_immediate();
    int bad;
    wr(8'h81);
    tone_interval(0, 544, "R5 latch low bits period 17");
    wr(8'h00); idle(40);
    bad = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (tone0_lvl != 9) bad++;
    end
    chk(bad == 0, "R6 period 1 constant high", bad, 0);
  endtask

  task automatic t_silence();
    int bad;
    wr(8'h9F); idle(3);
    bad = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (tone0_lvl != 0) bad++;
    end
    chk(bad == 0, "R7 attenuation 15 silent", bad, 0);
  endtask

  task automatic t_noise_periodic();
    wr(8'hF0);
    wr(8'hE7); wr(8'h00); idle(4);
    noise_shape(512, 8192, "R11 data byte periodic rate 0");
    wr(8'h01); idle(4);
    noise_shape(1024, 16384, "R8 periodic rate 1");
  endtask

  task automatic t_noise_white();
    logic [15:0] s;
    int bad;
    wr(8'hE4); idle(4);
    s = 16'h8000;
    while (!s[0]) s = {s[0] ^ s[3], s[15:1]};
    wait_high(3, 70000);
    idle(256);
    bad = 0;
    for (int j = 0; j < 24; j++) begin
      if ((noise_lvl != 0) != s[0]) bad++;
      s = {s[0] ^ s[3], s[15:1]};
      idle(512);
    end
    chk(bad == 0, "R9 white sequence", bad, 0);
  endtask

  task automatic t_noise_tone2();
    wr(8'hC4); wr(8'h00);
    wr(8'hE3); idle(4);
    noise_shape(128, 2048, "R10 rate 3 from tone 2");
  endtask

  task automatic t_mix();
    wr(8'hFF);
    wr(8'h81); wr(8'h00); wr(8'h93);
    wr(8'hA1); wr(8'h00); wr(8'hB5);
    wr(8'hC1); wr(8'h00); wr(8'hD8);
    idle(50);
    chk(tone0_lvl == 12 && tone1_lvl == 10 && tone2_lvl == 7 && noise_lvl == 0,
        "R12 levels", {tone0_lvl, tone1_lvl, tone2_lvl, noise_lvl}, 16'hCA70);
    chk(mix_out == 29, "R12 mix sum", mix_out, 29);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_latch_volume();
    t_data_volume();
    t_tone_period();
    t_tone_immediate();
    t_silence();
    t_noise_periodic();
    t_noise_white();
    t_noise_tone2();
    t_mix();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule